// File: doc/BRIEF.md
# Associative Road Finder

This block is a bank of stored track patterns that searches for matches while hits arrive. Each pattern holds one coarse-bin word for each detector layer. Every layer has its own hit bus, and each bus feeds a private comparator in every pattern. A comparator that sees its stored word on its own layer's bus latches that layer's hit flag. The flag stays set until the next event begins. When the number of latched layers in a pattern reaches a threshold, the pattern becomes a road. The threshold is a runtime register, so the bank can run with a majority such as five of six layers or demand all six.

Software or a sequencer drives the block through a 4-bit opcode. The opcodes load pattern words, clear the bank for a new event, set the threshold, and pop roads one at a time. Roads are read out lowest address first. Each road is reported once. A flag shows when no unreported road remains.

Top module: `assoc_road_finder`

## Requirements
- R1: While reset is held and after it is released, `road_valid` is 0 and `all_read` is 1. The threshold starts at N_LAYER-1, which is 5 by default.
- R2: Opcode 1 (write) stores `wr_data` as the word of layer `plane_sel` in pattern `pat_addr`. After the write only the new word matches on that layer, and the old word no longer does.
- R3: Lane L of `hit_words` is bits [12L+11:12L], qualified by `hit_valid[L]`. It is compared only against each pattern's layer-L word. A word equal to a pattern's word for a different layer sets nothing.
- R4: Hit flags are sticky and accumulate over any number of cycles. A repeated hit on a layer that is already flagged does not raise the count.
- R5: A pattern is a road when its flagged-layer count is at least the threshold. Opcode 3 loads the threshold from `wr_data[2:0]`, and the new value takes effect from the following cycle.
- R6: Opcode 4 (read) with a road pending sets `road_valid` in the next cycle. `road_addr` then carries the lowest pending road address, and that road is not reported again in the same event.
- R7: `all_read` is 1 exactly when no unreported road remains. A read issued while it is 1 leaves `road_valid` at 0 in the next cycle.
- R8: Opcode 2 (new event) clears every hit flag and every reported mark in one cycle. Stored words are kept. Hits presented in the same cycle are discarded.
- R9: All six lanes may carry hits in the same cycle, and each lane is latched independently.
- R10: A write with `plane_sel` of N_LAYER or above changes no stored word.
- R11: Any cycle whose opcode is not read leaves `road_valid` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Opcode: 0 idle, 1 write, 2 new event, 3 set threshold, 4 read |
| pat_addr | input | 7 | Pattern address for writes |
| plane_sel | input | 3 | Layer selected for writes |
| wr_data | input | 12 | Word to store, or threshold in bits [2:0] |
| hit_valid | input | 6 | Per-lane hit qualifier |
| hit_words | input | 72 | Six 12-bit hit words, lane 0 in the low bits |
| road_valid | output | 1 | Registered: a road address is presented |
| road_addr | output | 7 | Registered address of the road popped |
| all_read | output | 1 | No unreported road remains |

## Verification
The checker watches every cycle for the readout handshake:
- A read with a road pending yields `road_valid` in the next cycle.
- A read with nothing pending, or any other opcode, yields none.
- A new-event opcode empties the bank in one cycle.
- The threshold never moves except on its own opcode.

Only the bench's scenarios can show the following:
- The pattern-specific outcomes: which addresses come out and in what order.
- That words seen on the wrong lane are rejected, and that repeated hits are counted once.
- That overwritten and ignored writes behave as required.
- That a threshold change turns a five-layer pattern into a road or out of one.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic [3:0] {
    OP_IDLE       = 4'd0,
    OP_WRITE      = 4'd1,
    OP_NEW_EVENT  = 4'd2,
    OP_SET_THRESH = 4'd3,
    OP_READ       = 4'd4
  } am_op_e;
endpackage

// File: rtl/am_pattern.sv
// One stored pattern: per-layer words, private comparators, sticky flags,
// layer tally and road decision.
module am_pattern #(
  parameter int N_LAYER = 6,
  parameter int WORD_W  = 12,
  parameter int CNT_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [N_LAYER-1:0]         wr_plane,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [N_LAYER-1:0]         hit_valid,
  input  logic [N_LAYER*WORD_W-1:0]  hit_words,
  input  logic                       clr,
  input  logic [CNT_W-1:0]           thr,
  input  logic                       take,
  output logic                       road
);
  logic [N_LAYER-1:0] match;
  logic [N_LAYER-1:0] hit_q, hit_d;
  logic               taken_q, taken_d;
  logic [CNT_W-1:0]   count;

  for (genvar l = 0; l < N_LAYER; l++) begin : g_layer
    logic [WORD_W-1:0] word_q;
    // storage word: no reset, loaded only through the write path
    always_ff @(posedge clk) begin
      if (wr_en && wr_plane[l]) word_q <= wr_data;
    end
    assign match[l] = hit_valid[l] && (hit_words[l*WORD_W +: WORD_W] == word_q);
  end

  always_comb begin
    hit_d   = clr ? '0 : (hit_q | match);
    taken_d = clr ? 1'b0 : (taken_q | take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      taken_q <= taken_d;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N_LAYER; i++) count = count + CNT_W'(hit_q[i]);
  end

  assign road = (count >= thr) && !taken_q;
endmodule

// File: rtl/am_prio_enc.sv
// Lowest-index-first encoder with one-hot grant.
module am_prio_enc #(
  parameter int N     = 128,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  assign gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/am_ctrl.sv
// Opcode decode, threshold register and registered readout port.
module am_ctrl
  import am_pkg::*;
#(
  parameter int N_LAYER = 6,
  parameter int ADDR_W  = 7,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         op,
  input  logic [SEL_W-1:0]   plane_sel,
  input  logic [CNT_W-1:0]   thr_data,
  input  logic               any_road,
  input  logic [ADDR_W-1:0]  road_idx,
  output logic               write_en,
  output logic [N_LAYER-1:0] plane_oh,
  output logic               clr,
  output logic               take_en,
  output logic [CNT_W-1:0]   thr,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr
);
  logic               is_read, thr_en;
  logic [CNT_W-1:0]   thr_q;
  logic               valid_q, valid_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               addr_en;

  assign write_en = (op == OP_WRITE);
  assign clr      = (op == OP_NEW_EVENT);
  assign thr_en   = (op == OP_SET_THRESH);
  assign is_read  = (op == OP_READ);
  assign take_en  = is_read && any_road;

  // out-of-range plane selects decode to no layer at all
  for (genvar l = 0; l < N_LAYER; l++) begin : g_plane
    assign plane_oh[l] = (plane_sel == SEL_W'(l));
  end

  always_comb begin
    valid_d = take_en;
    addr_en = take_en;
    addr_d  = road_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= CNT_W'(N_LAYER - 1);
    else if (thr_en) thr_q <= thr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign thr       = thr_q;
  assign out_valid = valid_q;
  assign out_addr  = addr_q;
endmodule

// File: rtl/assoc_road_finder.sv
module assoc_road_finder
  import am_pkg::*;
#(
  parameter int N_PAT   = 128,
  parameter int N_LAYER = 6,
  parameter int WORD_W  = 12,
  parameter int OP_W    = 4,
  parameter int ADDR_W  = $clog2(N_PAT),
  parameter int SEL_W   = $clog2(N_LAYER + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OP_W-1:0]           op,
  input  logic [ADDR_W-1:0]         pat_addr,
  input  logic [SEL_W-1:0]          plane_sel,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [N_LAYER-1:0]        hit_valid,
  input  logic [N_LAYER*WORD_W-1:0] hit_words,
  output logic                      road_valid,
  output logic [ADDR_W-1:0]         road_addr,
  output logic                      all_read
);
  localparam int CNT_W = $clog2(N_LAYER + 1);

  logic               write_en, clr, take_en, any_road;
  logic [N_LAYER-1:0] plane_oh;
  logic [CNT_W-1:0]   thr;
  logic [N_PAT-1:0]   road, gnt;
  logic [ADDR_W-1:0]  road_idx;

  am_ctrl #(
    .N_LAYER(N_LAYER), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .plane_sel(plane_sel),
    .thr_data(wr_data[CNT_W-1:0]), .any_road(any_road), .road_idx(road_idx),
    .write_en(write_en), .plane_oh(plane_oh), .clr(clr), .take_en(take_en),
    .thr(thr), .out_valid(road_valid), .out_addr(road_addr)
  );

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    am_pattern #(.N_LAYER(N_LAYER), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_pat (
      .clk(clk), .rst_n(rst_n),
      .wr_en(write_en && (pat_addr == ADDR_W'(p))),
      .wr_plane(plane_oh), .wr_data(wr_data),
      .hit_valid(hit_valid), .hit_words(hit_words),
      .clr(clr), .thr(thr), .take(take_en && gnt[p]),
      .road(road[p])
    );
  end

  am_prio_enc #(.N(N_PAT), .IDX_W(ADDR_W)) u_enc (
    .req(road), .gnt(gnt), .idx(road_idx), .any(any_road)
  );

  assign all_read = !any_road;
endmodule

// File: rtl/am_checker.sv
module am_checker
  import am_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op,
  input logic             road_valid,
  input logic             all_read,
  input logic [CNT_W-1:0] thr
);
  a_r6_read_yields_road: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && !all_read) |=> road_valid);

  a_r7_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && all_read) |=> !road_valid);

  a_r11_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) |=> !road_valid);

  a_r8_new_event_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEW_EVENT && thr != '0) |=> all_read);

  a_r5_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_SET_THRESH) |=> $stable(thr));
endmodule

bind assoc_road_finder am_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .road_valid(road_valid),
  .all_read(all_read), .thr(thr)
);

// File: tb/assoc_road_finder_bench.sv
module assoc_road_finder_bench;
  import am_pkg::*;

  localparam int NP = 128, NL = 6, WW = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      op;
  logic [6:0]      pat_addr;
  logic [2:0]      plane_sel;
  logic [WW-1:0]   wr_data;
  logic [NL-1:0]   hit_valid;
  logic [NL*WW-1:0] hit_words;
  logic            road_valid;
  logic [6:0]      road_addr;
  logic            all_read;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  assoc_road_finder u_assoc_road_finder (
    .clk(clk), .rst_n(rst_n), .op(op), .pat_addr(pat_addr),
    .plane_sel(plane_sel), .wr_data(wr_data), .hit_valid(hit_valid),
    .hit_words(hit_words), .road_valid(road_valid), .road_addr(road_addr),
    .all_read(all_read)
  );

  function automatic logic [WW-1:0] word_of(int p, int l);
    return 12'h400 | WW'(p << 3) | WW'(l);
  endfunction

  function automatic logic [NL*WW-1:0] words_of(int p);
    logic [NL*WW-1:0] w;
    for (int l = 0; l < NL; l++) w[l*WW +: WW] = word_of(p, l);
    return w;
  endfunction

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle();
    op = OP_IDLE; hit_valid = '0; hit_words = '0;
  endtask

  task automatic do_op(logic [3:0] o, int a, int s, logic [WW-1:0] d);
    op = o; pat_addr = 7'(a); plane_sel = 3'(s); wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic send(logic [3:0] o, logic [NL-1:0] mask, logic [NL*WW-1:0] w);
    op = o; hit_valid = mask; hit_words = w;
    @(negedge clk); idle();
  endtask

  // driver: push the expected road, then issue the read
  task automatic read_expect(int a, string req);
    exp_q.push_back(a); tag_q.push_back(req);
    op = OP_READ;
    @(negedge clk); idle();
  endtask

  // monitor: compare each presented road against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && road_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R7: got road %0d expected none", road_addr);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(road_addr), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [NL*WW-1:0] w;
    rst_n = 1'b0; idle(); pat_addr = '0; plane_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(road_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(road_valid), 0);
    check("R1 all_read after reset", int'(all_read), 1);

    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) do_op(OP_WRITE, p, l, word_of(p, l));
    check("R1 no road after load", int'(all_read), 1);

    // R4: hits accumulate, repeated layer counted once
    send(OP_IDLE, 6'b000011, words_of(3));
    send(OP_IDLE, 6'b001101, words_of(3));
    check("R4 four layers no road", int'(all_read), 1);
    send(OP_IDLE, 6'b010000, words_of(3));
    check("R5 default five layers is road", int'(all_read), 0);
    // R9: all lanes in one cycle
    send(OP_IDLE, 6'b111111, words_of(9));
    send(OP_IDLE, 6'b001111, words_of(20));
    // R3: swapped lanes must not match
    w = words_of(40);
    w[1*WW +: WW] = word_of(40, 2);
    w[2*WW +: WW] = word_of(40, 1);
    send(OP_IDLE, 6'b111111, w);
    read_expect(3, "R6 lowest first");
    read_expect(9, "R9 six lanes one cycle");
    check("R3 R7 nothing left", int'(all_read), 1);
    do_op(OP_READ, 0, 0, '0);
    check("R7 empty read no valid", int'(road_valid), 0);

    // R8: clear; simultaneous hits discarded; words kept
    send(OP_NEW_EVENT, 6'b111111, words_of(50));
    check("R8 cleared and same-cycle hits dropped", int'(all_read), 1);
    send(OP_IDLE, 6'b111111, words_of(9));
    send(OP_IDLE, 6'b100000, words_of(3));
    check("R8 words kept", int'(all_read), 0);
    read_expect(9, "R8 re-found after clear");
    check("R8 old flags gone", int'(all_read), 1);

    // R5: six of six
    do_op(OP_SET_THRESH, 0, 0, 12'd6);
    do_op(OP_NEW_EVENT, 0, 0, '0);
    send(OP_IDLE, 6'b011111, words_of(60));
    send(OP_IDLE, 6'b111111, words_of(61));
    send(OP_IDLE, 6'b111111, words_of(62));
    read_expect(61, "R5 six of six");
    read_expect(62, "R6 next address");
    check("R5 five not enough at six", int'(all_read), 1);
    do_op(OP_SET_THRESH, 0, 0, 12'd5);
    check("R5 lowered threshold", int'(all_read), 0);
    read_expect(60, "R5 five of six after lowering");
    check("R7 drained", int'(all_read), 1);

    // R2 and R10: overwrite and ignored write
    do_op(OP_WRITE, 70, 7, 12'h000);
    do_op(OP_WRITE, 80, 2, 12'hABC);
    do_op(OP_SET_THRESH, 0, 0, 12'd6);
    do_op(OP_NEW_EVENT, 0, 0, '0);
    send(OP_IDLE, 6'b111111, words_of(80));
    check("R2 old word rejected", int'(all_read), 1);
    send(OP_IDLE, 6'b000100, {{(NL-3)*WW{1'b0}}, 12'hABC, {2*WW{1'b0}}});
    check("R2 new word matches", int'(all_read), 0);
    send(OP_IDLE, 6'b111111, words_of(70));
    read_expect(70, "R10 ignored write kept words");
    read_expect(80, "R2 rewritten pattern");
    check("R7 final empty", int'(all_read), 1);

    @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule